// File: doc/BRIEF.md
# Byte Stream to Halfword Program Packer

This block sits in front of a flash word-program engine and turns a byte-addressed write request into a series of 16-bit program requests. A request carries a destination address and a byte count. The data bytes then arrive one at a time on a valid/ready stream. The block pairs the bytes into halfwords and hands each halfword to the downstream engine with its even address. It then waits for the engine's completion code before it builds the next word.

The byte at the even address goes into the upper half of the word, and the byte after it goes into the lower half. If the count is odd, one byte is left over at the end. In that case the block fetches the byte that is already stored at the following odd address through a small read port. It merges that byte into the lower half, so the write leaves the neighbouring byte unchanged.

The block refuses a request whose destination is odd. A zero-length request finishes at once. The first non-zero completion code from the engine ends the transfer, and that code is reported. The outcome is shown on a one-cycle done pulse together with a result kind and a code, which hold until the next result.

Top module: `halfword_packer`

## Requirements
- R1: A request with req_addr bit 0 set is answered with done in the cycle after acceptance, with done_kind = 1 (alignment). No write request and no read request are issued.
- R2: While two or more bytes remain, the earlier byte is placed in wr_data[15:8] and the next byte in wr_data[7:0]. The word is issued at the current address, which starts at req_addr and rises by 2 with each write.
- R3: When exactly one byte remains, the block issues one read with rd_addr equal to the word address plus 1. It then issues one write with the last byte in wr_data[15:8] and rd_resp_data in wr_data[7:0].
- R4: A write completion with a non-zero wr_resp_err ends the transfer. done follows in the next cycle with done_kind = 2 and done_code equal to that error value. No further write is issued and no further byte is accepted.
- R5: When every write completes with a zero code, done is raised with done_kind = 0 after exactly ceil(req_len/2) writes, and every byte has been consumed.
- R6: A request with an even address and req_len = 0 is answered with done in the next cycle, with done_kind = 0, and no write is issued.
- R7: req_ready is high only while the block is idle. in_ready is high only while the block waits for a data byte, and never together with wr_valid.
- R8: Once wr_valid is raised, wr_valid, wr_addr and wr_data stay unchanged until wr_ready is seen.
- R9: done is a single-cycle pulse, and done_kind and done_code keep their values until the next done.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Transfer request present |
| req_ready | output | 1 | Block is idle and accepts a request |
| req_addr | input | ADDR_W | Byte destination address |
| req_len | input | LEN_W | Number of bytes to write |
| in_valid | input | 1 | Data byte present |
| in_ready | output | 1 | Block takes a data byte |
| in_data | input | 8 | Data byte |
| wr_valid | output | 1 | Halfword program request |
| wr_ready | input | 1 | Engine accepts the program request |
| wr_addr | output | ADDR_W | Even halfword address |
| wr_data | output | 16 | Halfword to program |
| wr_resp_valid | input | 1 | Program completion |
| wr_resp_err | input | ERR_W | Completion code, zero on success |
| rd_valid | output | 1 | Read of the stored neighbour byte, held until answered |
| rd_addr | output | ADDR_W | Odd address of the byte to read |
| rd_resp_valid | input | 1 | Read data present |
| rd_resp_data | input | 8 | Stored byte |
| done | output | 1 | One-cycle end-of-transfer pulse |
| done_kind | output | 2 | 0 success, 1 alignment, 2 program error |
| done_code | output | ERR_W | Engine error code for kind 2, else zero |

## Verification
The assertions assume that the engine raises wr_resp_valid only while a write is outstanding, and rd_resp_valid only while rd_valid is high. They also assume that req_valid is not held high beyond one request. The bench meets these assumptions with a responder that answers a fixed number of cycles after each handshake, and with a driver that pulses each request once. It sweeps lengths 0 to 9 at two even bases, and for each case it injects an error at several write positions. It also sends odd start addresses. wr_ready is stalled in a repeating pattern so that the hold rule is exercised.

// File: rtl/hwp_pkg.sv
package hwp_pkg;

    typedef enum logic [2:0] {
        S_IDLE  = 3'd0,
        S_FILL  = 3'd1,
        S_TAIL  = 3'd2,
        S_ISSUE = 3'd3,
        S_WAIT  = 3'd4,
        S_DONE  = 3'd5
    } hwp_state_e;

    typedef enum logic [1:0] {
        K_OK    = 2'd0,
        K_ALIGN = 2'd1,
        K_WRERR = 2'd2
    } hwp_kind_e;

    typedef struct packed {
        logic [7:0] hi;
        logic [7:0] lo;
    } hw_word_t;

    function automatic logic [15:0] word_bits(input hw_word_t w);
        return {w.hi, w.lo};
    endfunction

endpackage

// File: rtl/hwp_datapath.sv
module hwp_datapath
    import hwp_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int LEN_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_len,
    input  logic              take,
    input  logic [7:0]        in_data,
    input  logic              tail_fill,
    input  logic [7:0]        rd_resp_data,
    input  logic              advance,
    output logic [ADDR_W-1:0] cur_addr,
    output hw_word_t          word,
    output logic              have_hi,
    output logic              rem_one,
    output logic              rem_zero
);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(2);
    localparam logic [LEN_W-1:0]  ONE  = LEN_W'(1);

    logic [LEN_W-1:0] rem_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_addr <= '0;
            rem_q    <= '0;
            word     <= '0;
            have_hi  <= 1'b0;
        end else begin
            if (start) begin
                cur_addr <= req_addr;
                rem_q    <= req_len;
                have_hi  <= 1'b0;
            end
            if (take) begin
                rem_q <= rem_q - ONE;
                if (!have_hi) begin
                    word.hi <= in_data;
                    have_hi <= 1'b1;
                end else begin
                    word.lo <= in_data;
                    have_hi <= 1'b0;
                end
            end
            if (tail_fill) begin
                word.lo <= rd_resp_data;
                have_hi <= 1'b0;
            end
            if (advance) begin
                cur_addr <= cur_addr + STEP;
            end
        end
    end

    assign rem_one  = (rem_q == ONE);
    assign rem_zero = (rem_q == '0);

endmodule

// File: rtl/hwp_ctrl.sv
module hwp_ctrl
    import hwp_pkg::*;
#(
    parameter int ERR_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic             req_odd,
    input  logic             req_empty,
    input  logic             in_valid,
    input  logic             have_hi,
    input  logic             rem_one,
    input  logic             rem_zero,
    input  logic             wr_ready,
    input  logic             wr_resp_valid,
    input  logic [ERR_W-1:0] wr_resp_err,
    input  logic             rd_resp_valid,
    output logic             req_ready,
    output logic             in_ready,
    output logic             wr_valid,
    output logic             rd_valid,
    output logic             done,
    output logic             start,
    output logic             take,
    output logic             tail_fill,
    output logic             advance,
    output logic [1:0]       done_kind,
    output logic [ERR_W-1:0] done_code
);
    hwp_state_e       state_q, state_d;
    hwp_kind_e        kind_q, kind_d;
    logic [ERR_W-1:0] code_q, code_d;
    logic             resp_bad;

    assign req_ready = (state_q == S_IDLE);
    assign in_ready  = (state_q == S_FILL);
    assign rd_valid  = (state_q == S_TAIL);
    assign wr_valid  = (state_q == S_ISSUE);
    assign done      = (state_q == S_DONE);
    assign start     = req_valid && req_ready;
    assign take      = in_valid && in_ready;
    assign tail_fill = rd_valid && rd_resp_valid;
    assign resp_bad  = (wr_resp_err != '0);
    assign advance   = (state_q == S_WAIT) && wr_resp_valid && !resp_bad;

    always_comb begin
        state_d = state_q;
        kind_d  = kind_q;
        code_d  = code_q;
        case (state_q)
            S_IDLE: if (start) begin
                if (req_odd) begin
                    state_d = S_DONE;
                    kind_d  = K_ALIGN;
                    code_d  = '0;
                end else if (req_empty) begin
                    state_d = S_DONE;
                    kind_d  = K_OK;
                    code_d  = '0;
                end else begin
                    state_d = S_FILL;
                end
            end
            S_FILL: if (take) begin
                if (have_hi)      state_d = S_ISSUE;
                else if (rem_one) state_d = S_TAIL;
            end
            S_TAIL:  if (rd_resp_valid) state_d = S_ISSUE;
            S_ISSUE: if (wr_ready)      state_d = S_WAIT;
            S_WAIT: if (wr_resp_valid) begin
                if (resp_bad) begin
                    state_d = S_DONE;
                    kind_d  = K_WRERR;
                    code_d  = wr_resp_err;
                end else if (rem_zero) begin
                    state_d = S_DONE;
                    kind_d  = K_OK;
                    code_d  = '0;
                end else begin
                    state_d = S_FILL;
                end
            end
            S_DONE:  state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= S_IDLE;
            kind_q  <= K_OK;
            code_q  <= '0;
        end else begin
            state_q <= state_d;
            kind_q  <= kind_d;
            code_q  <= code_d;
        end
    end

    assign done_kind = kind_q;
    assign done_code = code_q;

    p_align_reject_r1: assert property (@(posedge clk) disable iff (rst)
        (start && req_odd) |=> (done && done_kind == K_ALIGN && !wr_valid && !rd_valid));

    p_empty_ok_r6: assert property (@(posedge clk) disable iff (rst)
        (start && !req_odd && req_empty) |=> (done && done_kind == K_OK));

    p_abort_code_r4: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_WAIT && wr_resp_valid && resp_bad)
        |=> (done && done_kind == K_WRERR && done_code == $past(wr_resp_err)));

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        done |=> (!done && req_ready && $stable(done_kind) && $stable(done_code)));

    p_wr_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && !wr_ready) |=> wr_valid);

endmodule

// File: rtl/halfword_packer.sv
module halfword_packer
    import hwp_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int LEN_W  = 8,
    parameter int ERR_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_len,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [7:0]        in_data,
    output logic              wr_valid,
    input  logic              wr_ready,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [15:0]       wr_data,
    input  logic              wr_resp_valid,
    input  logic [ERR_W-1:0]  wr_resp_err,
    output logic              rd_valid,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_resp_valid,
    input  logic [7:0]        rd_resp_data,
    output logic              done,
    output logic [1:0]        done_kind,
    output logic [ERR_W-1:0]  done_code
);
    localparam logic [ADDR_W-1:0] NEIGHBOUR = ADDR_W'(1);

    logic              start, take, tail_fill, advance;
    logic              have_hi, rem_one, rem_zero;
    logic [ADDR_W-1:0] cur_addr;
    hw_word_t          word;

    hwp_ctrl #(.ERR_W(ERR_W)) ctrl_i (
        .clk           (clk),
        .rst           (rst),
        .req_valid     (req_valid),
        .req_odd       (req_addr[0]),
        .req_empty     (req_len == '0),
        .in_valid      (in_valid),
        .have_hi       (have_hi),
        .rem_one       (rem_one),
        .rem_zero      (rem_zero),
        .wr_ready      (wr_ready),
        .wr_resp_valid (wr_resp_valid),
        .wr_resp_err   (wr_resp_err),
        .rd_resp_valid (rd_resp_valid),
        .req_ready     (req_ready),
        .in_ready      (in_ready),
        .wr_valid      (wr_valid),
        .rd_valid      (rd_valid),
        .done          (done),
        .start         (start),
        .take          (take),
        .tail_fill     (tail_fill),
        .advance       (advance),
        .done_kind     (done_kind),
        .done_code     (done_code)
    );

    hwp_datapath #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) dp_i (
        .clk          (clk),
        .rst          (rst),
        .start        (start),
        .req_addr     (req_addr),
        .req_len      (req_len),
        .take         (take),
        .in_data      (in_data),
        .tail_fill    (tail_fill),
        .rd_resp_data (rd_resp_data),
        .advance      (advance),
        .cur_addr     (cur_addr),
        .word         (word),
        .have_hi      (have_hi),
        .rem_one      (rem_one),
        .rem_zero     (rem_zero)
    );

    assign wr_addr = cur_addr;
    assign wr_data = word_bits(word);
    assign rd_addr = cur_addr + NEIGHBOUR;

    p_even_word_r2: assert property (@(posedge clk) disable iff (rst)
        wr_valid |-> !wr_addr[0]);

    p_tail_merge_r3: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && rd_resp_valid) |=> (wr_valid && wr_data[7:0] == $past(rd_resp_data)));

    p_data_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && !wr_ready) |=> ($stable(wr_data) && $stable(wr_addr)));

    p_stream_excl_r7: assert property (@(posedge clk) disable iff (rst)
        in_ready |-> (!req_ready && !wr_valid && !rd_valid));

endmodule

// File: tb/halfword_packer_tb_top.sv
module halfword_packer_tb_top;
    localparam int AW = 16;
    localparam int LW = 8;
    localparam int EW = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0, req_ready;
    logic [AW-1:0] req_addr = '0;
    logic [LW-1:0] req_len = '0;
    logic          in_valid = 1'b0, in_ready;
    logic [7:0]    in_data = '0;
    logic          wr_valid, wr_ready = 1'b0;
    logic [AW-1:0] wr_addr;
    logic [15:0]   wr_data;
    logic          wr_resp_valid = 1'b0;
    logic [EW-1:0] wr_resp_err = '0;
    logic          rd_valid;
    logic [AW-1:0] rd_addr;
    logic          rd_resp_valid = 1'b0;
    logic [7:0]    rd_resp_data = '0;
    logic          done;
    logic [1:0]    done_kind;
    logic [EW-1:0] done_code;

    always #4 clk = ~clk;

    halfword_packer #(.ADDR_W(AW), .LEN_W(LW), .ERR_W(EW)) dut_i (.*);

    int            n_chk = 0, n_fail = 0, cyc = 0;
    logic [7:0]    mem [256];
    logic [AW-1:0] wl_addr [16];
    logic [15:0]   wl_data [16];
    logic [AW-1:0] rl_addr;
    int            nw = 0, nrd = 0, err_at = -1, resp_cnt = 0, rd_cnt = 0;
    logic [EW-1:0] err_code = '0;
    bit            hold_pend = 0;
    logic [15:0]   hold_data;
    logic [AW-1:0] hold_addr;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] bval(input logic [7:0] seed, input int i);
        return 8'(int'(seed) + i * 37);
    endfunction

    // Downstream engine and read port model
    initial begin
        forever begin
            @(negedge clk);
            cyc++;
            wr_resp_valid = 1'b0;
            wr_resp_err   = '0;
            rd_resp_valid = 1'b0;
            if (hold_pend) begin
                chk(wr_valid && wr_data == hold_data && wr_addr == hold_addr,
                    "R8", "stalled request held", longint'(wr_data), longint'(hold_data));
                hold_pend = 0;
            end
            if (resp_cnt > 0) begin
                resp_cnt--;
                if (resp_cnt == 0) begin
                    wr_resp_valid = 1'b1;
                    wr_resp_err   = (nw - 1 == err_at) ? err_code : '0;
                end
            end
            wr_ready = (cyc % 3) != 1;
            if (wr_valid) begin
                if (wr_ready) begin
                    if (nw < 16) begin
                        wl_addr[nw] = wr_addr;
                        wl_data[nw] = wr_data;
                    end
                    nw++;
                    resp_cnt = 2;
                end else begin
                    hold_pend = 1;
                    hold_data = wr_data;
                    hold_addr = wr_addr;
                end
            end
            if (rd_cnt > 0) begin
                rd_cnt--;
                if (rd_cnt == 0) begin
                    rd_resp_valid = 1'b1;
                    rd_resp_data  = mem[rd_addr[7:0]];
                    rl_addr       = rd_addr;
                    nrd++;
                end
            end else if (rd_valid) begin
                rd_cnt = 2;
            end
        end
    end

    task automatic run(input logic [AW-1:0] a, input int len, input int ea,
                       input logic [EW-1:0] ec, input logic [7:0] seed);
        int         i = 0, guard = 0, nexp, exp_b, ew;
        bit         rdy_seen = 0;
        logic [1:0] k = '0;
        logic [EW-1:0] c = '0;
        logic [7:0] lo;
        nw = 0; nrd = 0; err_at = ea; err_code = ec;
        @(negedge clk);
        chk(req_ready, "R7", "ready while idle", longint'(req_ready), 1);
        req_valid = 1'b1; req_addr = a; req_len = LW'(len);
        @(negedge clk);
        req_valid = 1'b0;
        forever begin
            if (in_valid && rdy_seen) i++;
            if (done) begin
                k = done_kind; c = done_code;
                break;
            end
            if (guard == 0 && len > 0 && !a[0])
                chk(!req_ready, "R7", "busy refuses request", longint'(req_ready), 0);
            in_valid = (i < len) && ((guard % 4) != 3);
            in_data  = bval(seed, i);
            rdy_seen = in_ready;
            guard++;
            if (guard > 2000) begin
                chk(0, "R5", "transfer never finished", guard, 0);
                break;
            end
            @(negedge clk);
        end
        in_valid = 1'b0;
        @(negedge clk);
        chk(!done && done_kind == k && done_code == c, "R9", "done pulse and held result",
            longint'(done), 0);
        if (a[0]) begin
            chk(k == 2'd1, "R1", "odd address kind", k, 1);
            chk(nw == 0 && nrd == 0 && i == 0, "R1", "no traffic on odd address", nw, 0);
        end else if (len == 0) begin
            chk(k == 2'd0, "R6", "empty kind", k, 0);
            chk(nw == 0, "R6", "empty writes", nw, 0);
        end else begin
            nexp = (len + 1) / 2;
            if (ea >= 0 && ea < nexp) begin
                ew    = ea + 1;
                exp_b = (2 * ew < len) ? 2 * ew : len;
                chk(k == 2'd2, "R4", "abort kind", k, 2);
                chk(c == ec, "R4", "abort code", c, ec);
                chk(nw == ew, "R4", "writes before abort", nw, ew);
                chk(i == exp_b, "R4", "bytes taken before abort", i, exp_b);
            end else begin
                ew = nexp;
                chk(k == 2'd0 && c == '0, "R5", "success kind", k, 0);
                chk(nw == nexp, "R5", "write count", nw, nexp);
                chk(i == len, "R5", "bytes taken", i, len);
            end
            chk(nrd == (((len % 2) == 1 && nw == nexp) ? 1 : 0), "R3", "tail reads",
                nrd, ((len % 2) == 1 && nw == nexp) ? 1 : 0);
            for (int w = 0; w < nw && w < 16; w++) begin
                chk(wl_addr[w] == a + AW'(2 * w), "R2", "word address",
                    longint'(wl_addr[w]), longint'(a + AW'(2 * w)));
                if (2 * w + 1 < len) begin
                    lo = bval(seed, 2 * w + 1);
                    chk(wl_data[w] == {bval(seed, 2 * w), lo}, "R2", "packed word",
                        longint'(wl_data[w]), longint'({bval(seed, 2 * w), lo}));
                end else begin
                    lo = mem[8'(int'(a) + 2 * w + 1)];
                    chk(wl_data[w] == {bval(seed, 2 * w), lo}, "R3", "merged tail word",
                        longint'(wl_data[w]), longint'({bval(seed, 2 * w), lo}));
                    chk(rl_addr == a + AW'(2 * w + 1), "R3", "tail read address",
                        longint'(rl_addr), longint'(a + AW'(2 * w + 1)));
                end
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int txn = 0;
        logic [AW-1:0] bases [2];
        int errs [4];
        logic [AW-1:0] odds [2];
        int olens [4];
        bases = '{16'h0010, 16'h07FA};
        errs  = '{-1, 0, 1, 4};
        odds  = '{16'h0011, 16'h00FF};
        olens = '{0, 1, 2, 5};
        for (int m = 0; m < 256; m++) mem[m] = 8'(m * 29 + 3);
        repeat (3) @(negedge clk);
        chk(req_ready && !done && !in_ready && !wr_valid && !rd_valid && done_kind == 2'd0,
            "R7", "reset state", longint'({req_ready, done, in_ready, wr_valid, rd_valid}), 16);
        rst = 1'b0;
        for (int b = 0; b < 2; b++)
            for (int len = 0; len < 10; len++)
                for (int e = 0; e < 4; e++) begin
                    run(bases[b], len, errs[e], EW'(txn % 15 + 1), 8'(txn * 11 + 5));
                    txn++;
                end
        for (int o = 0; o < 2; o++)
            for (int l = 0; l < 4; l++) begin
                run(odds[o], olens[l], -1, 4'h1, 8'(txn * 11 + 5));
                txn++;
            end
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule